// File: doc/BRIEF.md
# VGA 1024x768 Raster Timing Generator

This block produces the raster timing for a 1024x768 display refreshed at 60 Hz from a single pixel clock of about 65 MHz. A horizontal counter steps on every clock through a 1344-clock scanline. A vertical counter steps once per completed scanline through an 806-line frame. From these two counts the block drives active-low horizontal and vertical sync, an active-video flag that is low across every porch and sync interval, and two single-clock strobes. The strobes fire at the start of each line and at the start of each frame and are meant to trigger external ramp circuits.

Each axis is a small counter paired with a four-state phase machine. The states are ACTIVE, FRONT, SYNC and BACK. ACTIVE goes to FRONT when the next count reaches the visible width. FRONT goes to SYNC when a one-clock set decode fires at the sync-start count. SYNC goes to BACK when a one-clock clear decode fires at the sync-end count. BACK goes to ACTIVE when the counter wraps to zero. The SYNC state therefore acts as a set/reset latch for the sync pulse. Every output is registered and is computed from the next count, so each output lines up with the count it describes. After a synchronous reset, the first cycle is pixel 0 of line 0.

Top module: `vga_raster_timing`

## Requirements
- R1: While reset is high and in the first cycle after it is released, both counts are 0, hsync_n and vsync_n are 1, and video_on, line_trig and frame_trig are all 1 (pixel 0 of line 0).
- R2: The horizontal count runs 0 to H_TOTAL-1 (default 1343) and then wraps to 0, so a line lasts H_TOTAL clocks.
- R3: video_on is 1 exactly when the horizontal count is below H_VIS (1024) and the vertical count is below V_VIS (768).
- R4: hsync_n is 0 exactly for horizontal counts H_SYNC_ON (1048) to H_SYNC_OFF-1 (1183), and 1 otherwise.
- R5: The vertical count changes only in the clock where the horizontal count wraps, and then it advances by one.
- R6: vsync_n is 0 exactly for lines V_SYNC_ON (771) to V_SYNC_OFF-1 (776), and 1 otherwise.
- R7: line_trig is 1 for exactly the one clock in which the horizontal count is 0.
- R8: The vertical count wraps to 0 after line V_TOTAL-1 (805). frame_trig is 1 only in the clock where both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video_on | output | 1 | High during visible pixels only |
| line_trig | output | 1 | One-clock strobe at the start of each line |
| frame_trig | output | 1 | One-clock strobe at the start of each frame |

## Verification
The hardest behaviour to reach from the ports is the vertical one. With the default sizes, vertical sync starts more than a million clocks after reset, and the frame wrap comes later still. The bench therefore runs a second copy of the block with small timing parameters and the same structure. It checks every output of that copy on every clock across two full frames against a model built from cycle counts. Alongside it, the default instance is checked at the exact horizontal boundary clocks, and it is reset in the middle of a line to confirm the restart.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_t;
endpackage

// File: rtl/vga_axis.sv
module vga_axis
    import vga_raster_pkg::*;
#(
    parameter int VIS      = 1024,
    parameter int SYNC_ON  = 1048,
    parameter int SYNC_OFF = 1184,
    parameter int TOTAL    = 1344,
    localparam int CW      = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] cnt,
    output phase_t        phase_nxt,
    output logic          at_last
);
    phase_t        phase;
    logic [CW-1:0] cnt_nxt;
    logic          sync_set;
    logic          sync_clr;

    assign at_last  = (cnt == CW'(TOTAL - 1));
    assign sync_set = adv && (cnt_nxt == CW'(SYNC_ON));
    assign sync_clr = adv && (cnt_nxt == CW'(SYNC_OFF));

    always_comb begin
        if (!adv)        cnt_nxt = cnt;
        else if (at_last) cnt_nxt = '0;
        else              cnt_nxt = cnt + CW'(1);
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_ACTIVE: if (adv && cnt_nxt == CW'(VIS)) phase_nxt = PH_FRONT;
            PH_FRONT:  if (sync_set)                   phase_nxt = PH_SYNC;
            PH_SYNC:   if (sync_clr)                   phase_nxt = PH_BACK;
            PH_BACK:   if (adv && at_last)             phase_nxt = PH_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= PH_ACTIVE;
        end else begin
            cnt   <= cnt_nxt;
            phase <= phase_nxt;
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < TOTAL);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (cnt == '0));
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && !at_last) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/vga_raster_timing.sv
module vga_raster_timing
    import vga_raster_pkg::*;
#(
    parameter int H_VIS      = 1024,
    parameter int H_SYNC_ON  = 1048,
    parameter int H_SYNC_OFF = 1184,
    parameter int H_TOTAL    = 1344,
    parameter int V_VIS      = 768,
    parameter int V_SYNC_ON  = 771,
    parameter int V_SYNC_OFF = 777,
    parameter int V_TOTAL    = 806
) (
    input  logic clk,
    input  logic rst,
    output logic hsync_n,
    output logic vsync_n,
    output logic video_on,
    output logic line_trig,
    output logic frame_trig
);
    localparam int HCW = $clog2(H_TOTAL);
    localparam int VCW = $clog2(V_TOTAL);

    logic [HCW-1:0] h_cnt;
    logic [VCW-1:0] v_cnt;
    phase_t         h_phase_nxt;
    phase_t         v_phase_nxt;
    logic           h_last;
    logic           v_last;

    vga_axis #(
        .VIS(H_VIS), .SYNC_ON(H_SYNC_ON), .SYNC_OFF(H_SYNC_OFF), .TOTAL(H_TOTAL)
    ) u_h_axis (
        .clk(clk), .rst(rst), .adv(1'b1),
        .cnt(h_cnt), .phase_nxt(h_phase_nxt), .at_last(h_last)
    );

    vga_axis #(
        .VIS(V_VIS), .SYNC_ON(V_SYNC_ON), .SYNC_OFF(V_SYNC_OFF), .TOTAL(V_TOTAL)
    ) u_v_axis (
        .clk(clk), .rst(rst), .adv(h_last),
        .cnt(v_cnt), .phase_nxt(v_phase_nxt), .at_last(v_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n    <= 1'b1;
            vsync_n    <= 1'b1;
            video_on   <= 1'b1;
            line_trig  <= 1'b1;
            frame_trig <= 1'b1;
        end else begin
            hsync_n    <= (h_phase_nxt != PH_SYNC);
            vsync_n    <= (v_phase_nxt != PH_SYNC);
            video_on   <= (h_phase_nxt == PH_ACTIVE) && (v_phase_nxt == PH_ACTIVE);
            line_trig  <= h_last;
            frame_trig <= h_last && v_last;
        end
    end

    assert_video_R3: assert property (@(posedge clk) disable iff (rst)
        video_on == ((int'(h_cnt) < H_VIS) && (int'(v_cnt) < V_VIS)));
    assert_hsync_R4: assert property (@(posedge clk) disable iff (rst)
        hsync_n == !((int'(h_cnt) >= H_SYNC_ON) && (int'(h_cnt) < H_SYNC_OFF)));
    assert_vsync_R6: assert property (@(posedge clk) disable iff (rst)
        vsync_n == !((int'(v_cnt) >= V_SYNC_ON) && (int'(v_cnt) < V_SYNC_OFF)));
    assert_line_trig_R7: assert property (@(posedge clk) disable iff (rst)
        line_trig == (h_cnt == '0));
    assert_frame_trig_R8: assert property (@(posedge clk) disable iff (rst)
        frame_trig == ((h_cnt == '0) && (v_cnt == '0)));
    assert_vwrap_R8: assert property (@(posedge clk) disable iff (rst)
        (h_last && v_last) |=> (v_cnt == '0));
endmodule

// File: tb/vga_raster_timing_tb.sv
`timescale 1ns/1ps
module vga_raster_timing_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic hs_d, vs_d, vid_d, lt_d, ft_d;
    logic hs_s, vs_s, vid_s, lt_s, ft_s;

    vga_raster_timing u_dut (
        .clk(clk), .rst(rst), .hsync_n(hs_d), .vsync_n(vs_d),
        .video_on(vid_d), .line_trig(lt_d), .frame_trig(ft_d)
    );

    localparam int SH_VIS = 16, SH_SON = 18, SH_SOFF = 21, SH_TOT = 24;
    localparam int SV_VIS = 8,  SV_SON = 9,  SV_SOFF = 11, SV_TOT = 13;

    vga_raster_timing #(
        .H_VIS(SH_VIS), .H_SYNC_ON(SH_SON), .H_SYNC_OFF(SH_SOFF), .H_TOTAL(SH_TOT),
        .V_VIS(SV_VIS), .V_SYNC_ON(SV_SON), .V_SYNC_OFF(SV_SOFF), .V_TOTAL(SV_TOT)
    ) u_small (
        .clk(clk), .rst(rst), .hsync_n(hs_s), .vsync_n(vs_s),
        .video_on(vid_s), .line_trig(lt_s), .frame_trig(ft_s)
    );

    // cycle[40:9] | hsync_n vsync_n video_on line_trig frame_trig [8:4] | req [3:0]
    localparam int NVEC = 13;
    localparam logic [40:0] VEC [NVEC] = '{
        {32'd0,    5'b11111, 4'd1},  // R1 first pixel of frame
        {32'd1,    5'b11100, 4'd7},  // R7 strobe lasts one clock
        {32'd1023, 5'b11100, 4'd3},  // R3 last visible pixel
        {32'd1024, 5'b11000, 4'd3},  // R3 blanking starts
        {32'd1047, 5'b11000, 4'd4},  // R4 before sync
        {32'd1048, 5'b01000, 4'd4},  // R4 sync starts
        {32'd1183, 5'b01000, 4'd4},  // R4 last sync clock
        {32'd1184, 5'b11000, 4'd4},  // R4 sync ends
        {32'd1343, 5'b11000, 4'd2},  // R2 last clock of line
        {32'd1344, 5'b11110, 4'd8},  // R8 line 1 start, no frame strobe
        {32'd1345, 5'b11100, 4'd2},  // R2 second line runs on
        {32'd2392, 5'b01000, 4'd4},  // R4 sync on line 1
        {32'd2688, 5'b11110, 4'd7}   // R7 line 2 strobe
    };

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: got %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    task automatic goto(input int k);
        while (cyc < k) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs held in reset state while reset is high
        chk(hs_d, 1'b1, "R1", "hsync_n in reset");
        chk(vid_d, 1'b1, "R1", "video_on in reset");
        chk(ft_s, 1'b1, "R1", "small frame_trig in reset");
        rst = 1'b0;
        cyc = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] e;
            string rq;
            e = VEC[i];
            goto(int'(e[40:9]));
            rq = $sformatf("R%0d", e[3:0]);
            chk(hs_d,  e[8], rq, "hsync_n");
            chk(vs_d,  e[7], rq, "vsync_n");
            chk(vid_d, e[6], rq, "video_on");
            chk(lt_d,  e[5], rq, "line_trig");
            chk(ft_d,  e[4], rq, "frame_trig");
        end

        // R1: reset in the middle of a line restarts at pixel 0 of line 0
        goto(2700);
        do_reset();
        chk(hs_d, 1'b1, "R1", "hsync_n after mid-line reset");
        chk(vid_d, 1'b1, "R1", "video_on after mid-line reset");
        chk(lt_d, 1'b1, "R1", "line_trig after mid-line reset");
        chk(ft_d, 1'b1, "R1", "frame_trig after mid-line reset");

        // Small instance: every clock across two frames and a bit more
        for (int k = 0; k < 2 * SH_TOT * SV_TOT + 10; k++) begin
            int h, v;
            goto(k);
            h = k % SH_TOT;
            v = (k / SH_TOT) % SV_TOT;
            chk(vid_s, (h < SH_VIS) && (v < SV_VIS), "R3", "small video_on");
            chk(hs_s, !((h >= SH_SON) && (h < SH_SOFF)), "R4", "small hsync_n");
            chk(vs_s, !((v >= SV_SON) && (v < SV_SOFF)), "R5 R6", "small vsync_n");
            chk(lt_s, (h == 0), "R2 R7", "small line_trig");
            chk(ft_s, (h == 0) && (v == 0), "R8", "small frame_trig");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule